// File: doc/BRIEF.md
# Boot Header Selector

This block sits between a reset sequencer and a configuration loader. A serial flash holds a small table of fixed-size headers at address zero, followed by the configuration images. Each header names where one image starts. Once reset is released, the block fetches the first header one byte at a time and decodes its mode flag. It then settles on one image start offset and passes that offset on to the loader.

When the flag is clear, the offset inside the first header is used directly. When the flag is set, two external select pins pick one of the four following headers, and that header's offset is used. After a selection has been delivered, a warm request with its own two-bit selector can repeat the choice among those four headers without a reset. Slots that hold no real image carry the offset of the first image, so every selector value yields a usable start address.

Flash access goes through a plain byte-read port. The block raises a request with an address and holds both until the flash side returns a data-valid strobe with the byte.

Top module: `boot_hdr_select`

## Requirements
- R1: While reset is asserted, rdReq and offsetValid are low and offset reads zero.
- R2: After reset the first flash access is address 0. Header 0 is read at bytes 0 to 3. The mode flag is bit 0 of byte 0. The image offset is a 24-bit big-endian value in bytes 1, 2 and 3, most significant byte first.
- R3: With the mode flag clear, the delivered offset is header 0's offset and bootHdr is 0.
- R4: With the mode flag set, the block reads bytes 1 to 3 of header 1+coldSel, where header h starts at address 32*h. It delivers that header's offset and sets bootHdr to 1+coldSel, for every selector value, including slots that alias the first image.
- R5: coldSel is sampled once, in the cycle after header 0's last byte arrives. Later changes on coldSel alter neither the address fetched nor the delivered offset.
- R6: Once a selection has been delivered, a one-cycle warmReq makes the block read header 1+warmSel and deliver its offset with bootHdr set to 1+warmSel. A warmReq that arrives while a fetch is in progress is ignored.
- R7: Only bytes 0 to 3 of headers 0 to 4 are ever addressed, so the 0xFF padding beyond them is never read as header data.
- R8: offsetValid is a single-cycle pulse, raised once per selection. offset and bootHdr hold their values until the next selection.
- R9: rdReq stays high with rdAddr unchanged until rdValid arrives, so any flash latency of one cycle or more is accepted.
- R10: Only bit 0 of header 0's byte 0 affects the choice. The other seven bits of that byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coldSel | input | 2 | External image select pins, used in cold-boot mode |
| warmReq | input | 1 | Warm reselection request, one cycle |
| warmSel | input | 2 | Image selector carried with warmReq |
| rdReq | output | 1 | Byte read request |
| rdAddr | output | 24 | Flash byte address of the request |
| rdData | input | 8 | Returned flash byte |
| rdValid | input | 1 | rdData is valid for the pending request |
| offset | output | 24 | Selected image start offset |
| offsetValid | output | 1 | One-cycle strobe marking a new offset |
| bootHdr | output | 3 | Index of the header the offset came from |

## Verification
The bench sweeps every combination of mode flag, selector value, number of real images (one to four) and flash latency (one to three cycles). Its model flash returns 0xFF outside header bytes 0 to 3, so a design that computes a wrong header base or fetches a padding byte delivers a visibly corrupted offset. Three kinds of late input are injected: coldSel is inverted as soon as the second header fetch begins, a warmReq is pulsed in the middle of the header-0 fetch, and noisy upper bits are put in byte 0. A design that resamples the pins, honours a warm request while busy, or decodes the whole flag byte would deliver the wrong header or a second pulse. Warm requests for all four selectors are then issued, and aliased slots must return the first image's offset.

// File: rtl/boot_hdr_pkg.sv
package boot_hdr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR0,
    ST_DECIDE,
    ST_SEL,
    ST_PUB,
    ST_DONE
  } bootState_t;

  typedef struct packed {
    logic capture;   // latch rdData and step to next byte
    logic startSel;  // load selected header index
    logic useWarm;   // selector comes from warmSel, else coldSel
    logic publish;   // move accumulated offset to the output
  } ctrlStrb_t;
endpackage

// File: rtl/boot_hdr_ctrl.sv
module boot_hdr_ctrl
  import boot_hdr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdValid,
  input  logic      lastByte,
  input  logic      coldFlag,
  input  logic      warmReq,
  output logic      rdReq,
  output ctrlStrb_t strb
);
  bootState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    rdReq     = 1'b0;
    unique case (state)
      ST_IDLE: nextState = ST_HDR0;
      ST_HDR0: begin
        rdReq = 1'b1;
        if (rdValid) begin
          strb.capture = 1'b1;
          if (lastByte) nextState = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (coldFlag) begin
          strb.startSel = 1'b1;
          nextState     = ST_SEL;
        end else begin
          nextState = ST_PUB;
        end
      end
      ST_SEL: begin
        rdReq = 1'b1;
        if (rdValid) begin
          strb.capture = 1'b1;
          if (lastByte) nextState = ST_PUB;
        end
      end
      ST_PUB: begin
        strb.publish = 1'b1;
        nextState    = ST_DONE;
      end
      ST_DONE: begin
        if (warmReq) begin
          strb.startSel = 1'b1;
          strb.useWarm  = 1'b1;
          nextState     = ST_SEL;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/boot_hdr_dpath.sv
module boot_hdr_dpath
  import boot_hdr_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int HDR_BYTES = 32,
  parameter int OFF_BYTES = 3,
  parameter int SEL_W     = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrb_t                  strb,
  input  logic [BYTE_W-1:0]          rdData,
  input  logic [SEL_W-1:0]           coldSel,
  input  logic [SEL_W-1:0]           warmSel,
  output logic [ADDR_W-1:0]          rdAddr,
  output logic                       lastByte,
  output logic                       coldFlag,
  output logic [OFF_BYTES*BYTE_W-1:0] offset,
  output logic                       offsetValid,
  output logic [$clog2((1<<SEL_W)+1)-1:0] bootHdr
);
  localparam int NUM_HDR = (1 << SEL_W) + 1;
  localparam int HIDX_W  = $clog2(NUM_HDR);
  localparam int CNT_W   = $clog2(OFF_BYTES + 1);
  localparam int OFF_W   = OFF_BYTES * BYTE_W;

  logic [HIDX_W-1:0] hdrIdx;
  logic [CNT_W-1:0]  byteIdx;
  logic [OFF_W-1:0]  acc;
  logic [SEL_W-1:0]  selPick;

  assign selPick  = strb.useWarm ? warmSel : coldSel;
  assign lastByte = (byteIdx == CNT_W'(OFF_BYTES));
  assign rdAddr   = ADDR_W'(hdrIdx) * ADDR_W'(HDR_BYTES) + ADDR_W'(byteIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrIdx      <= '0;
      byteIdx     <= '0;
      coldFlag    <= 1'b0;
      acc         <= '0;
      offset      <= '0;
      offsetValid <= 1'b0;
      bootHdr     <= '0;
    end else begin
      offsetValid <= strb.publish;
      if (strb.startSel) begin
        hdrIdx  <= HIDX_W'(selPick) + HIDX_W'(1);
        byteIdx <= CNT_W'(1);
        acc     <= '0;
      end else if (strb.capture) begin
        if (hdrIdx == '0 && byteIdx == '0) coldFlag <= rdData[0];
        else acc <= {acc[OFF_W-BYTE_W-1:0], rdData};
        byteIdx <= byteIdx + CNT_W'(1);
      end
      if (strb.publish) begin
        offset  <= acc;
        bootHdr <= hdrIdx;
      end
    end
  end
endmodule

// File: rtl/boot_hdr_select.sv
module boot_hdr_select
  import boot_hdr_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int HDR_BYTES = 32,
  parameter int OFF_BYTES = 3,
  parameter int SEL_W     = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [SEL_W-1:0]             coldSel,
  input  logic                         warmReq,
  input  logic [SEL_W-1:0]             warmSel,
  output logic                         rdReq,
  output logic [ADDR_W-1:0]            rdAddr,
  input  logic [7:0]                   rdData,
  input  logic                         rdValid,
  output logic [OFF_BYTES*8-1:0]       offset,
  output logic                         offsetValid,
  output logic [$clog2((1<<SEL_W)+1)-1:0] bootHdr
);
  ctrlStrb_t strb;
  logic      lastByte;
  logic      coldFlag;

  boot_hdr_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdValid  (rdValid),
    .lastByte (lastByte),
    .coldFlag (coldFlag),
    .warmReq  (warmReq),
    .rdReq    (rdReq),
    .strb     (strb)
  );

  boot_hdr_dpath #(
    .ADDR_W    (ADDR_W),
    .HDR_BYTES (HDR_BYTES),
    .OFF_BYTES (OFF_BYTES),
    .SEL_W     (SEL_W)
  ) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rdData      (rdData),
    .coldSel     (coldSel),
    .warmSel     (warmSel),
    .rdAddr      (rdAddr),
    .lastByte    (lastByte),
    .coldFlag    (coldFlag),
    .offset      (offset),
    .offsetValid (offsetValid),
    .bootHdr     (bootHdr)
  );
endmodule

// File: rtl/boot_hdr_select_chk.sv
module boot_hdr_select_chk #(
  parameter int ADDR_W    = 24,
  parameter int HDR_BYTES = 32,
  parameter int OFF_BYTES = 3,
  parameter int SEL_W     = 2
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         rdReq,
  input logic [ADDR_W-1:0]            rdAddr,
  input logic                         rdValid,
  input logic                         offsetValid,
  input logic [OFF_BYTES*8-1:0]       offset,
  input logic [$clog2((1<<SEL_W)+1)-1:0] bootHdr
);
  localparam int NUM_HDR = (1 << SEL_W) + 1;
  localparam int LOW_W   = $clog2(HDR_BYTES);
  localparam logic [ADDR_W-1:0] TABLE_END = ADDR_W'(NUM_HDR * HDR_BYTES);

  // R7: requests stay inside the used bytes of the header table
  p_addr_in_table_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdAddr < TABLE_END) && (rdAddr[LOW_W-1:0] <= LOW_W'(OFF_BYTES)));

  // R9: pending request holds its address until served
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> (rdReq && $stable(rdAddr)));

  // R8: strobe lasts one cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    offsetValid |=> !offsetValid);

  // R8: output held between selections
  p_offset_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !offsetValid |-> ($stable(offset) && $stable(bootHdr)));

  // R4: delivered header index is a real slot
  p_hdr_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    offsetValid |-> (32'(bootHdr) < NUM_HDR));

  // R8: no fetch is pending when a new offset is announced
  p_idle_on_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    offsetValid |-> !rdReq);
endmodule

bind boot_hdr_select boot_hdr_select_chk #(
  .ADDR_W    (ADDR_W),
  .HDR_BYTES (HDR_BYTES),
  .OFF_BYTES (OFF_BYTES),
  .SEL_W     (SEL_W)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rdReq       (rdReq),
  .rdAddr      (rdAddr),
  .rdValid     (rdValid),
  .offsetValid (offsetValid),
  .offset      (offset),
  .bootHdr     (bootHdr)
);

// File: tb/test_boot_hdr_select.sv
module test_boot_hdr_select;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  coldSel = 2'd0;
  logic        warmReq = 1'b0;
  logic [1:0]  warmSel = 2'd0;
  logic        rdReq;
  logic [23:0] rdAddr;
  logic [7:0]  rdData = 8'h00;
  logic        rdValid = 1'b0;
  logic [23:0] offset;
  logic        offsetValid;
  logic [2:0]  bootHdr;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int addrBad = 0;
  int cycles = 0;
  int lat = 1;
  int latCnt = 0;
  int numImg = 4;
  logic [7:0] byte0 = 8'h00;

  always #2 clk = ~clk;

  boot_hdr_select i_boot_hdr_select (
    .clk(clk), .rstN(rstN), .coldSel(coldSel), .warmReq(warmReq), .warmSel(warmSel),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .offset(offset), .offsetValid(offsetValid), .bootHdr(bootHdr)
  );

  function automatic logic [23:0] imgStart(int k);
    return 24'h0000A0 + 24'(k) * 24'h012300;
  endfunction

  // header 0 names the last real image; slots past numImg alias image 0
  function automatic logic [23:0] hdrOff(int h);
    if (h == 0) return imgStart(numImg - 1);
    if (h - 1 < numImg) return imgStart(h - 1);
    return imgStart(0);
  endfunction

  function automatic logic [7:0] memByte(logic [23:0] a);
    int h = int'(a) / 32;
    int b = int'(a) % 32;
    logic [23:0] o;
    if (h >= 5 || b > 3) return 8'hFF;
    if (b == 0) return (h == 0) ? byte0 : 8'h00;
    o = hdrOff(h);
    return o[8*(3-b) +: 8];
  endfunction

  // flash model with programmable latency
  always @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      latCnt  <= 0;
    end else if (rdValid) begin
      rdValid <= 1'b0;
      latCnt  <= 0;
    end else if (rdReq) begin
      if (latCnt >= lat - 1) begin
        rdValid <= 1'b1;
        rdData  <= memByte(rdAddr);
        latCnt  <= 0;
      end else latCnt <= latCnt + 1;
    end
  end

  always @(posedge clk) if (rstN && offsetValid) pulses <= pulses + 1;

  always @(negedge clk)
    if (rstN && rdReq && (rdAddr >= 24'd160 || (rdAddr % 32) > 3)) addrBad++;

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      finishRun();
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic waitValid(input bit scramble, input logic [1:0] sel, input bit inject,
                           output bit got, output logic [23:0] firstAddr);
    bit seenReq = 0;
    got = 0;
    firstAddr = 24'hFFFFFF;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rdReq && !seenReq) begin seenReq = 1; firstAddr = rdAddr; end
      if (scramble && rdReq && rdAddr >= 24'd32) coldSel = ~sel;
      warmReq = (inject && i == 3);
      if (offsetValid) begin got = 1; break; end
    end
    warmReq = 1'b0;
  endtask

  task automatic boot(int nImg, int l, bit flag, logic [1:0] sel);
    bit got;
    logic [23:0] fa, hold;
    int expHdr;
    numImg = nImg; lat = l;
    byte0 = {7'(int'(sel) * 37 + l), flag};   // R10: noisy upper bits
    coldSel = sel;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rdReq && !offsetValid && offset == 24'd0, "R1 reset state",
        {rdReq, offsetValid, 6'd0, offset}, 32'd0);
    pulses = 0;
    rstN = 1'b1;
    waitValid(flag, sel, 1'b1, got, fa);
    expHdr = flag ? 1 + int'(sel) : 0;
    chk(fa == 24'd0, "R2 first address", 32'(fa), 32'd0);
    chk(got, "R8 offsetValid seen", 32'(got), 32'd1);
    chk(offset == hdrOff(expHdr), flag ? "R4/R5/R7/R9 cold offset" : "R3/R10 default offset",
        32'(offset), 32'(hdrOff(expHdr)));
    chk(int'(bootHdr) == expHdr, "R3/R4/R6 bootHdr", 32'(bootHdr), 32'(expHdr));
    hold = offset;
    coldSel = sel + 2'd1;   // R5: late pin change
    repeat (20) @(negedge clk);
    chk(pulses == 1 && offset == hold, "R5/R6/R8 single pulse, held offset",
        32'(pulses), 32'd1);
  endtask

  task automatic warm(logic [1:0] s);
    bit got;
    logic [23:0] fa;
    pulses = 0;
    warmSel = s;
    @(negedge clk); warmReq = 1'b1;
    @(negedge clk); warmReq = 1'b0;
    waitValid(1'b0, 2'd0, 1'b0, got, fa);
    chk(got && offset == hdrOff(1 + int'(s)), "R6 warm offset",
        32'(offset), 32'(hdrOff(1 + int'(s))));
    chk(int'(bootHdr) == 1 + int'(s), "R6 warm bootHdr", 32'(bootHdr), 32'(1 + int'(s)));
    repeat (8) @(negedge clk);
    chk(pulses == 1, "R8 warm single pulse", 32'(pulses), 32'd1);
  endtask

  initial begin
    for (int n = 1; n <= 4; n++)
      for (int l = 1; l <= 3; l++)
        for (int f = 0; f < 2; f++)
          for (int s = 0; s < 4; s++) begin
            boot(n, l, f[0], 2'(s));
            if (s == 3 && f == 1)
              for (int w = 0; w < 4; w++) warm(2'(w));
          end
    chk(addrBad == 0, "R7 padding never addressed", 32'(addrBad), 32'd0);
    finishRun();
  end
endmodule